// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block watches a bank of external interrupt lines and decides, line by line, when an edge on one of them counts as an interrupt event. Each line has a three-bit trigger mode that says independently whether a rising change and whether a falling change fires. An event on a masked line is thrown away. Events on the upper lines latch into a pending register that software clears by writing ones. Events on the lowest lines go straight to a dedicated output each and are never latched.

The pending lines are gathered into two level outputs for a downstream interrupt controller: one for a small low group and one for the wide high group. Each output stays high while any unmasked pending bit of its group is set. A small register port gives read and write access to the trigger modes, the mask, the pending register and two filter words. The filter words are storage only. The inputs are taken as already synchronous to `clk`. An edge is found by comparing each line with the level it had on the previous cycle.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset, the mask reads 0x00FFFFF0 and the pending register reads 0. All three mode words read 0, and every interrupt output is low.
- R2: A rising change on an unmasked line fires when its mode is 1, 4, 5, 6 or 7. It does not fire for modes 0, 2 or 3.
- R3: A falling change on an unmasked line fires when its mode is 0, 2, 3, 6 or 7. It does not fire for modes 1, 4 or 5.
- R4: An event on a line whose mask bit is 1 is dropped. It sets no pending bit and raises no output, and it stays lost after the line is unmasked.
- R5: An event on line k (k from 0 to 3) drives `irq_direct[k]` high for exactly the one cycle after the edge. It never sets a pending bit, and pending bits 3:0 always read 0.
- R6: `irq_grp_lo` is high while any pending bit 4 to 7 is set with its mask bit clear. `irq_grp_hi` does the same for bits 8 to 23. A pending bit becomes visible one cycle after the edge.
- R7: A write to the pending register (address 4) clears each bit written as 1 and leaves bits written as 0 unchanged. A new event in the same cycle as its clear leaves the bit set.
- R8: A write to the mask register (address 3) keeps only bits 4 to 23. All other bits read 0.
- R9: The mode of line i sits in the word at address i/8, bits 4*(i%8)+2 down to 4*(i%8). Bit 3 of every nibble reads 0.
- R10: The two filter words (addresses 5 and 6) read back what was written and have no effect on events.
- R11: An event needs a change of level between two consecutive cycles. A line held at a steady level fires nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 24 | External interrupt lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select: 0-2 mode words, 3 mask, 4 pending, 5-6 filter |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |
| irq_direct | output | 4 | One-cycle event pulses for lines 0 to 3 |
| irq_grp_lo | output | 1 | Level request for unmasked pending lines 4 to 7 |
| irq_grp_hi | output | 1 | Level request for unmasked pending lines 8 to 23 |

## Verification
The hardest case to reach from the ports is a pending-register clear that lands in the same cycle as a fresh edge on the same line. The stimulus raises the line and issues the write-one-to-clear in one cycle, then reads the bit back. It must still be set. The bench also walks all eight modes through both edge directions on one unmasked line. It masks a line whose bit is already pending, to show that the group output follows the mask while the pending bit stays set.

// File: rtl/eirq_pkg.sv
// Shared definitions for the external interrupt edge controller:
// register selects and the trigger-mode decode. Assumes 3-bit modes.
package eirq_pkg;

    typedef enum logic [2:0] {
        SEL_MODE0 = 3'd0,
        SEL_MODE1 = 3'd1,
        SEL_MODE2 = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_PEND  = 3'd4,
        SEL_FILT0 = 3'd5,
        SEL_FILT1 = 3'd6
    } reg_sel_e;

    // True when the mode arms the line for a rising change
    function automatic logic mode_rise_en(input logic [2:0] mode);
        return (mode == 3'd1) || mode[2];
    endfunction

    // True when the mode arms the line for a falling change
    function automatic logic mode_fall_en(input logic [2:0] mode);
        return (mode == 3'd0) || (mode == 3'd2) || (mode == 3'd3) ||
               (mode == 3'd6) || (mode == 3'd7);
    endfunction

endpackage

// File: rtl/eirq_edge_detect.sv
// Registers each line's level every cycle and flags a rising or falling
// change against that stored level. Assumes inputs are already synchronous.
module eirq_edge_detect #(
    parameter int unsigned N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_in,
    output logic [N-1:0] prev_q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    // Hold the level seen on the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line_in;
    end

    // Compare the current level with the stored one
    always_comb begin
        rise = line_in & ~prev_q;
        fall = ~line_in & prev_q;
    end

endmodule

// File: rtl/eirq_trigger.sv
// Applies each line's trigger mode to its rise/fall flags to decide whether
// the line fires this cycle. Purely combinational, one slice per line.
module eirq_trigger #(
    parameter int unsigned N  = 24,
    parameter int unsigned MW = 3
) (
    input  logic [N*MW-1:0] mode_flat,
    input  logic [N-1:0]    rise,
    input  logic [N-1:0]    fall,
    output logic [N-1:0]    fire
);
    import eirq_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [2:0] m;
        // Widen the line's mode field to the decode width
        assign m = 3'(mode_flat[i*MW +: MW]);
        // A line fires when the change it saw is armed by its mode
        assign fire[i] = (rise[i] & mode_rise_en(m)) | (fall[i] & mode_fall_en(m));
    end

endmodule

// File: rtl/eirq_regfile.sv
// Holds the mode, mask, pending and filter registers. Applies the mask to
// fired lines and latches events on the upper lines into pending. Pending
// bits are cleared by writing ones; a new event wins over a same-cycle clear.
module eirq_regfile #(
    parameter int unsigned N       = 24,
    parameter int unsigned NDIRECT = 4,
    parameter int unsigned MW      = 3,
    parameter int unsigned DW      = 32,
    parameter int unsigned AW      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [N-1:0]    fire,
    output logic [DW-1:0]   rdata,
    output logic [N*MW-1:0] mode_flat,
    output logic [N-1:0]    mask_q,
    output logic [N-1:0]    pend_q,
    output logic [N-1:0]    evt
);
    import eirq_pkg::*;

    localparam int unsigned PITCH = 4;
    localparam int unsigned LPW   = DW / PITCH;
    localparam int unsigned NWORD = (N + LPW - 1) / LPW;
    localparam logic [N-1:0] IMPL = {{(N-NDIRECT){1'b1}}, {NDIRECT{1'b0}}};

    logic [MW-1:0] mode_q [N];
    logic [DW-1:0] filt0_q, filt1_q;
    logic [DW-1:0] mode_word [NWORD];
    logic [N-1:0]  clr;
    reg_sel_e      sel;

    assign sel = reg_sel_e'(addr);

    // Per-line mode storage, written from its word's nibble
    for (genvar i = 0; i < N; i++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[i] <= '0;
            else if (wr_en && (32'(addr) == i / LPW))
                mode_q[i] <= wdata[(i % LPW) * PITCH +: MW];
        end
        assign mode_flat[i*MW +: MW] = mode_q[i];
    end

    // Reassemble mode words for readback, unused nibble bits as zero
    always_comb begin
        for (int k = 0; k < NWORD; k++) begin
            mode_word[k] = '0;
            for (int j = 0; j < LPW; j++) begin
                if (k * LPW + j < N)
                    mode_word[k][j*PITCH +: MW] = mode_q[k*LPW + j];
            end
        end
    end

    // Mask register, only the latched lines are implemented
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= IMPL;
        else if (wr_en && sel == SEL_MASK) mask_q <= wdata[N-1:0] & IMPL;
    end

    // Masked lines produce no event
    assign evt = fire & ~mask_q;

    // Write-one-to-clear request for the pending register
    assign clr = (wr_en && sel == SEL_PEND) ? wdata[N-1:0] : '0;

    // Pending register: clear by ones, then set by new events
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~clr) | evt) & IMPL;
    end

    // Filter words are storage only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt0_q <= '0;
            filt1_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_FILT0) filt0_q <= wdata;
            if (sel == SEL_FILT1) filt1_q <= wdata;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        if (32'(addr) < NWORD) begin
            for (int k = 0; k < NWORD; k++)
                if (32'(addr) == k) rdata = mode_word[k];
        end else begin
            case (sel)
                SEL_MASK:  rdata = DW'(mask_q);
                SEL_PEND:  rdata = DW'(pend_q);
                SEL_FILT0: rdata = filt0_q;
                SEL_FILT1: rdata = filt1_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ext_irq_edge_ctrl.sv
// Top of the external interrupt edge controller. Detects edges, applies
// modes and mask, pulses a dedicated output per low line and raises two
// grouped level outputs from unmasked pending bits. Inputs must already be
// synchronous to clk.
module ext_irq_edge_ctrl #(
    parameter int unsigned NUM_LINES  = 24,
    parameter int unsigned NUM_DIRECT = 4,
    parameter int unsigned GRP_SPLIT  = 8,
    parameter int unsigned MODE_W     = 3,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  line_in,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_grp_lo,
    output logic                  irq_grp_hi
);

    logic [NUM_LINES-1:0]        prev_q, rise, fall, fire, evt;
    logic [NUM_LINES-1:0]        mask_q, pend_q, active;
    logic [NUM_LINES*MODE_W-1:0] mode_flat;

    eirq_edge_detect #(.N(NUM_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .prev_q(prev_q), .rise(rise), .fall(fall)
    );

    eirq_trigger #(.N(NUM_LINES), .MW(MODE_W)) u_trig (
        .mode_flat(mode_flat), .rise(rise), .fall(fall), .fire(fire)
    );

    eirq_regfile #(
        .N(NUM_LINES), .NDIRECT(NUM_DIRECT), .MW(MODE_W),
        .DW(DATA_W), .AW(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .fire(fire), .rdata(rdata), .mode_flat(mode_flat),
        .mask_q(mask_q), .pend_q(pend_q), .evt(evt)
    );

    // One-cycle pulse per dedicated line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_direct <= '0;
        else        irq_direct <= evt[NUM_DIRECT-1:0];
    end

    // Grouped level requests from unmasked pending bits
    assign active     = pend_q & ~mask_q;
    assign irq_grp_lo = |active[GRP_SPLIT-1:NUM_DIRECT];
    assign irq_grp_hi = |active[NUM_LINES-1:GRP_SPLIT];

endmodule

// File: rtl/eirq_checker.sv
// Property checks for the external interrupt edge controller, bound to the top.
module eirq_checker #(
    parameter int unsigned N       = 24,
    parameter int unsigned NDIRECT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N-1:0]       line_in,
    input logic [N-1:0]       prev_q,
    input logic [N-1:0]       mask_q,
    input logic [N-1:0]       pend_q,
    input logic [NDIRECT-1:0] irq_direct,
    input logic               irq_grp_lo,
    input logic               irq_grp_hi
);

    // R5
    pend_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[NDIRECT-1:0] == '0);

    // R8
    mask_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[NDIRECT-1:0] == '0);

    // R4
    masked_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0));

    // R11
    pend_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(line_in ^ prev_q)) == '0));

    // R6
    grp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (!irq_grp_lo && !irq_grp_hi));

    for (genvar i = 0; i < NDIRECT; i++) begin : g_dir
        // R5
        direct_after_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_direct[i] |-> $past(line_in[i] ^ prev_q[i]));
    end

endmodule

bind ext_irq_edge_ctrl eirq_checker #(.N(NUM_LINES), .NDIRECT(NUM_DIRECT)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .prev_q(prev_q),
    .mask_q(mask_q), .pend_q(pend_q), .irq_direct(irq_direct),
    .irq_grp_lo(irq_grp_lo), .irq_grp_hi(irq_grp_hi)
);

// File: tb/test_ext_irq_edge_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_edge_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] line_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq_direct;
    logic        irq_grp_lo, irq_grp_hi;

    int n_vec = 0;
    int n_bad = 0;
    logic [2:0]  mode_sh [24];
    logic [31:0] mask_sh = 32'h00FF_FFF0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    ext_irq_edge_ctrl i_ext_irq_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_direct(irq_direct),
        .irq_grp_lo(irq_grp_lo), .irq_grp_hi(irq_grp_hi)
    );

    function automatic logic exp_rise(input logic [2:0] m);
        return (m == 3'd1) || (m >= 3'd4);
    endfunction

    function automatic logic exp_fall(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd2) || (m == 3'd3) || (m >= 3'd6);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic set_mode(input int line, input logic [2:0] m);
        logic [31:0] w;
        mode_sh[line] = m;
        w = '0;
        for (int j = 0; j < 8; j++) w[j*4 +: 3] = mode_sh[(line/8)*8 + j];
        wr(3'(line / 8), w);
    endtask

    task automatic set_mask(input logic [31:0] m);
        mask_sh = m & 32'h00FF_FFF0;
        wr(3'd3, m);
    endtask

    task automatic clear_pend();
        wr(3'd4, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        rd(3'd3, v); check("R1 mask", v, 32'h00FF_FFF0);
        rd(3'd4, v); check("R1 pending", v, 32'h0);
        for (int k = 0; k < 3; k++) begin
            rd(3'(k), v); check("R1 mode word", v, 32'h0);
        end
        check("R1 outputs", {26'h0, irq_direct, irq_grp_lo, irq_grp_hi}, 32'h0);
    endtask

    task automatic t_modes();
        set_mask(mask_sh & ~32'h0000_0100);
        for (int m = 0; m < 8; m++) begin
            set_mode(8, 3'(m));
            clear_pend();
            line_in[8] = 1'b1; tick();
            rd(3'd4, v); check($sformatf("R2 rise mode %0d", m), {31'h0, v[8]}, {31'h0, exp_rise(3'(m))});
            clear_pend();
            line_in[8] = 1'b0; tick();
            rd(3'd4, v); check($sformatf("R3 fall mode %0d", m), {31'h0, v[8]}, {31'h0, exp_fall(3'(m))});
        end
        clear_pend();
    endtask

    task automatic t_mask();
        set_mode(9, 3'd1);
        line_in[9] = 1'b1; tick();
        rd(3'd4, v); check("R4 masked pend", v, 32'h0);
        check("R4 masked grp_hi", {31'h0, irq_grp_hi}, 32'h0);
        set_mask(mask_sh & ~32'h0000_0200);
        rd(3'd4, v); check("R4 after unmask pend", v, 32'h0);
        check("R4 after unmask grp_hi", {31'h0, irq_grp_hi}, 32'h0);
        line_in[9] = 1'b0; tick();
        set_mask(32'hFFFF_FFFF);
        rd(3'd3, v); check("R8 mask all ones", v, 32'h00FF_FFF0);
        set_mask(32'h0);
        rd(3'd3, v); check("R8 mask zero", v, 32'h0);
        clear_pend();
        set_mask(32'h00FF_FFF0);
    endtask

    task automatic t_direct();
        set_mode(2, 3'd1);
        line_in[2] = 1'b1; tick();
        check("R5 line2 pulse", {28'h0, irq_direct}, 32'h4);
        rd(3'd4, v); check("R5 no pending low", v, 32'h0);
        tick();
        check("R5 pulse one cycle", {28'h0, irq_direct}, 32'h0);
        line_in[0] = 1'b1; tick();
        check("R2 line0 mode0 no rise", {28'h0, irq_direct}, 32'h0);
        line_in[0] = 1'b0; tick();
        check("R5 line0 fall pulse", {28'h0, irq_direct}, 32'h1);
        line_in[2] = 1'b0; tick(); tick();
    endtask

    task automatic t_group();
        set_mode(5, 3'd1); set_mode(20, 3'd1);
        set_mask(32'h00FF_FFF0 & ~32'h0010_0020);
        clear_pend();
        line_in[5] = 1'b1; tick();
        check("R6 lo group", {30'h0, irq_grp_lo, irq_grp_hi}, 32'h2);
        line_in[20] = 1'b1; tick();
        check("R6 both groups", {30'h0, irq_grp_lo, irq_grp_hi}, 32'h3);
        set_mask(mask_sh | 32'h20);
        check("R6 masked pending drops lo", {30'h0, irq_grp_lo, irq_grp_hi}, 32'h1);
        rd(3'd4, v); check("R6 pending kept", v, 32'h0010_0020);
        set_mask(mask_sh & ~32'h20);
        check("R6 unmask restores lo", {31'h0, irq_grp_lo}, 32'h1);
        wr(3'd4, 32'h0);
        rd(3'd4, v); check("R7 write zero keeps", v, 32'h0010_0020);
        wr(3'd4, 32'h20);
        rd(3'd4, v); check("R7 clear one bit", v, 32'h0010_0000);
        check("R6 lo drops after clear", {30'h0, irq_grp_lo, irq_grp_hi}, 32'h1);
        line_in[20] = 1'b0; tick();
        clear_pend();
        // R7 new event in same cycle as clear
        line_in[20] = 1'b1;
        addr = 3'd4; wdata = 32'h0010_0000; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        rd(3'd4, v); check("R7 set wins over clear", v, 32'h0010_0000);
        line_in[20] = 1'b0; line_in[5] = 1'b0; tick();
        clear_pend();
    endtask

    task automatic t_format();
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R9 mode word format", v, 32'h7777_7777);
        wr(3'd1, 32'h0000_0010);
        rd(3'd1, v); check("R9 line9 field", v, 32'h0000_0010);
        for (int j = 0; j < 8; j++) mode_sh[16 + j] = 3'd7;
        for (int j = 0; j < 8; j++) mode_sh[8 + j] = 3'd0;
        mode_sh[9] = 3'd1;
    endtask

    task automatic t_filter();
        rd(3'd4, v);
        wr(3'd5, 32'hA5A5_A5A5);
        wr(3'd6, 32'h3C3C_0F0F);
        rd(3'd5, v); check("R10 filt0 readback", v, 32'hA5A5_A5A5);
        rd(3'd6, v); check("R10 filt1 readback", v, 32'h3C3C_0F0F);
        set_mode(12, 3'd1);
        set_mask(mask_sh & ~32'h1000);
        line_in[12] = 1'b1; tick();
        rd(3'd4, v); check("R10 event unaffected by filter", v, 32'h0000_1000);
        clear_pend();
    endtask

    task automatic t_level();
        rd(3'd4, v); check("R11 start clear", v, 32'h0);
        tick(); tick(); tick();
        rd(3'd4, v); check("R11 held level no refire", v, 32'h0);
        check("R11 grp_hi idle", {31'h0, irq_grp_hi}, 32'h0);
        line_in[12] = 1'b0; tick();
        rd(3'd4, v); check("R11 mode1 fall no fire", v, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 24; i++) mode_sh[i] = 3'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_modes();
        t_mask();
        t_direct();
        t_group();
        t_format();
        t_filter();
        t_level();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule